// File: doc/BRIEF.md
# Connection Table with Deadline Assignment

This block keeps the per-connection forwarding state used by the time-constrained traffic class of a mesh router, along with one horizon register for each output port. A local processor fills the table through a narrow control port. Each table entry is built from several small writes. The first three writes only load holding registers. The last write names the incoming connection and copies the whole entry into the table in one cycle, so a partly built entry is never visible.

When a time-constrained packet header arrives, the header logic presents its incoming connection number and its logical arrival time. One cycle later the block returns three values: the connection number to place in the header for the next node, the set of output ports the packet leaves on, and the local deadline. The local deadline is the arrival time plus the connection's local delay bound, computed modulo 256 on the 8-bit packet-time clock. The next node uses this deadline as the packet's logical arrival time. A multicast connection has several mask bits set and uses one deadline for all of its ports.

Top module: `ctab_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` is 0 and every horizon register reads 0.
- R2: Command codes 0 (next-hop id, `cfg_data[ID_W-1:0]`), 1 (delay, `cfg_data[TIME_W-1:0]`) and 2 (port mask, `cfg_data[NPORT-1:0]`) only load holding registers. A lookup made after these writes and before a commit still returns the old entry.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high. It is low in every other cycle.
- R4: `rsp_deadline` equals `lk_arrival` plus the stored delay, modulo 2^TIME_W. It wraps without any flag.
- R5: A stored mask with several bits set is returned unchanged. All ports in that mask share the one deadline.
- R6: Command code 3 writes the held next-hop id, delay and mask into the table at index `cfg_data[CONN_W-1:0]`. A lookup of that index in the same cycle returns the previous contents. A later lookup returns the new contents.
- R7: Command code 4 loads `cfg_data[TIME_W-1:0]` into the horizon register of every port p for which `cfg_data[TIME_W+p]` is 1. All other horizon registers keep their values. Port p's horizon appears on `hz_o[p*TIME_W +: TIME_W]`.
- R8: The response returns the next-hop id held at the time of the commit, for the entry that was looked up.
- R9: Command codes 5 to 7 are ignored. They change neither the holding registers, the table, nor any horizon register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_cmd | input | 3 | Control command code |
| cfg_data | input | TIME_W+NPORT (13) | Control write data |
| lk_req | input | 1 | Lookup request from the header logic |
| lk_conn | input | CONN_W (8) | Incoming connection number |
| lk_arrival | input | TIME_W (8) | Logical arrival time of the packet |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_out_id | output | ID_W (8) | Connection number for the next node |
| rsp_mask | output | NPORT (5) | Output port mask |
| rsp_deadline | output | TIME_W (8) | Local deadline, modulo 2^TIME_W |
| hz_o | output | NPORT*TIME_W (40) | All per-port horizon values, port 0 in the low bits |

## Verification
Lookups are made against several kinds of entry: a single-port entry with a small delay, a multicast entry, and an entry whose arrival time plus delay crosses 255. Together these separate a correct modulo sum from a saturating or widened one, and a passed-through mask from a one-hot decode. Two further patterns check what becomes visible and when. Lookups between staging writes and the commit, and a lookup in the same cycle as the commit, show whether the table changes only on the commit and whether a read returns the old word. Horizon writes with disjoint masks, followed by reserved command codes, show that each port updates only when its own mask bit is set.

// File: rtl/ctab_pkg.sv
package ctab_pkg;
  typedef enum logic [2:0] {
    CMD_NEXT_ID = 3'd0,
    CMD_DELAY   = 3'd1,
    CMD_PORTS   = 3'd2,
    CMD_COMMIT  = 3'd3,
    CMD_HORIZON = 3'd4
  } ctab_cmd_e;
endpackage

// File: rtl/ctab_cfg_stage.sv
module ctab_cfg_stage
  import ctab_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int TIME_W = 8,
  parameter int NPORT  = 5,
  parameter int CONN_W = 8,
  localparam int DATA_W  = TIME_W + NPORT,
  localparam int ENTRY_W = ID_W + TIME_W + NPORT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_cmd,
  input  logic [DATA_W-1:0]  cfg_data,
  output logic               tbl_we,
  output logic [CONN_W-1:0]  tbl_addr,
  output logic [ENTRY_W-1:0] tbl_word,
  output logic               hz_we,
  output logic [NPORT-1:0]   hz_sel,
  output logic [TIME_W-1:0]  hz_val
);
  logic [ID_W-1:0]   held_id;
  logic [TIME_W-1:0] held_delay;
  logic [NPORT-1:0]  held_ports;
  logic              is_valid_cmd;
  ctab_cmd_e         cmd;

  always_comb begin
    is_valid_cmd = (cfg_cmd <= 3'd4);
    cmd = is_valid_cmd ? ctab_cmd_e'(cfg_cmd) : CMD_NEXT_ID;
  end

  // Holding registers: loaded by the first three commands only
  always_ff @(posedge clk) begin
    if (rst) begin
      held_id    <= '0;
      held_delay <= '0;
      held_ports <= '0;
    end else if (cfg_we && is_valid_cmd) begin
      case (cmd)
        CMD_NEXT_ID: held_id    <= cfg_data[ID_W-1:0];
        CMD_DELAY:   held_delay <= cfg_data[TIME_W-1:0];
        CMD_PORTS:   held_ports <= cfg_data[NPORT-1:0];
        default: ;
      endcase
    end
  end

  // Commit and horizon strobes
  always_comb begin
    tbl_we   = cfg_we && is_valid_cmd && (cmd == CMD_COMMIT);
    tbl_addr = cfg_data[CONN_W-1:0];
    tbl_word = {held_id, held_delay, held_ports};
    hz_we    = cfg_we && is_valid_cmd && (cmd == CMD_HORIZON);
    hz_sel   = cfg_data[TIME_W +: NPORT];
    hz_val   = cfg_data[TIME_W-1:0];
  end
endmodule

// File: rtl/ctab_mem.sv
module ctab_mem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 21,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] store [DEPTH];

  // Read-first single-clock RAM: a same-cycle read sees the old word
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/ctab_horizon.sv
module ctab_horizon #(
  parameter int TIME_W = 8,
  parameter int NPORT  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [NPORT-1:0]        sel,
  input  logic [TIME_W-1:0]       val,
  output logic [NPORT*TIME_W-1:0] hz_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [TIME_W-1:0] hreg;
    always_ff @(posedge clk) begin
      if (rst) hreg <= '0;
      else if (we && sel[p]) hreg <= val;
    end
    assign hz_o[p*TIME_W +: TIME_W] = hreg;
  end
endmodule

// File: rtl/ctab_resp.sv
module ctab_resp #(
  parameter int ID_W   = 8,
  parameter int TIME_W = 8,
  parameter int NPORT  = 5,
  localparam int ENTRY_W = ID_W + TIME_W + NPORT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_req,
  input  logic [TIME_W-1:0]  lk_arrival,
  input  logic [ENTRY_W-1:0] rd_word,
  output logic               rsp_valid,
  output logic [ID_W-1:0]    rsp_out_id,
  output logic [NPORT-1:0]   rsp_mask,
  output logic [TIME_W-1:0]  rsp_deadline,
  output logic [TIME_W-1:0]  rd_delay
);
  logic [TIME_W-1:0] arr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      arr_q     <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) arr_q <= lk_arrival;
    end
  end

  always_comb begin
    rsp_out_id   = rd_word[ENTRY_W-1 -: ID_W];
    rd_delay     = rd_word[NPORT +: TIME_W];
    rsp_mask     = rd_word[NPORT-1:0];
    rsp_deadline = arr_q + rd_delay;  // modulo 2^TIME_W by width
  end
endmodule

// File: rtl/ctab_top.sv
module ctab_top
  import ctab_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int TIME_W = 8,
  parameter int NPORT  = 5,
  parameter int CONN_W = 8,
  localparam int DATA_W  = TIME_W + NPORT,
  localparam int ENTRY_W = ID_W + TIME_W + NPORT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_cmd,
  input  logic [DATA_W-1:0]       cfg_data,
  input  logic                    lk_req,
  input  logic [CONN_W-1:0]       lk_conn,
  input  logic [TIME_W-1:0]       lk_arrival,
  output logic                    rsp_valid,
  output logic [ID_W-1:0]         rsp_out_id,
  output logic [NPORT-1:0]        rsp_mask,
  output logic [TIME_W-1:0]       rsp_deadline,
  output logic [NPORT*TIME_W-1:0] hz_o
);
  logic               tbl_we;
  logic [CONN_W-1:0]  tbl_addr;
  logic [ENTRY_W-1:0] tbl_word;
  logic [ENTRY_W-1:0] rd_word;
  logic               hz_we;
  logic [NPORT-1:0]   hz_sel;
  logic [TIME_W-1:0]  hz_val;
  logic [TIME_W-1:0]  rd_delay;

  ctab_cfg_stage #(.ID_W(ID_W), .TIME_W(TIME_W), .NPORT(NPORT), .CONN_W(CONN_W)) i_stage (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cmd(cfg_cmd), .cfg_data(cfg_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_word(tbl_word),
    .hz_we(hz_we), .hz_sel(hz_sel), .hz_val(hz_val)
  );

  ctab_mem #(.ADDR_W(CONN_W), .WORD_W(ENTRY_W)) i_mem (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_word),
    .re(lk_req), .raddr(lk_conn), .rdata(rd_word)
  );

  ctab_horizon #(.TIME_W(TIME_W), .NPORT(NPORT)) i_hz (
    .clk(clk), .rst(rst), .we(hz_we), .sel(hz_sel), .val(hz_val), .hz_o(hz_o)
  );

  ctab_resp #(.ID_W(ID_W), .TIME_W(TIME_W), .NPORT(NPORT)) i_resp (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_arrival(lk_arrival), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_out_id(rsp_out_id), .rsp_mask(rsp_mask),
    .rsp_deadline(rsp_deadline), .rd_delay(rd_delay)
  );
endmodule

// File: rtl/ctab_checker.sv
module ctab_checker #(
  parameter int TIME_W = 8,
  parameter int NPORT  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_we,
  input logic [2:0]              cfg_cmd,
  input logic [TIME_W+NPORT-1:0] cfg_data,
  input logic                    lk_req,
  input logic [TIME_W-1:0]       lk_arrival,
  input logic                    rsp_valid,
  input logic [TIME_W-1:0]       rsp_deadline,
  input logic [TIME_W-1:0]       rd_delay,
  input logic [NPORT*TIME_W-1:0] hz_o
);
  logic [TIME_W-1:0] back_diff;
  assign back_diff = rsp_deadline - rd_delay;

  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);
  assert_rsp_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);
  assert_deadline_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !rst) |=> (back_diff == $past(lk_arrival)));

  for (genvar p = 0; p < NPORT; p++) begin : g_hz
    assert_hz_load_R7: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_cmd == 3'd4 && cfg_data[TIME_W+p])
        |=> (hz_o[p*TIME_W +: TIME_W] == $past(cfg_data[TIME_W-1:0])));
    assert_hz_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && cfg_cmd == 3'd4 && cfg_data[TIME_W+p])
        |=> $stable(hz_o[p*TIME_W +: TIME_W]));
  end
endmodule

bind ctab_top ctab_checker #(.TIME_W(TIME_W), .NPORT(NPORT)) i_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cmd(cfg_cmd), .cfg_data(cfg_data),
  .lk_req(lk_req), .lk_arrival(lk_arrival), .rsp_valid(rsp_valid),
  .rsp_deadline(rsp_deadline), .rd_delay(rd_delay), .hz_o(hz_o)
);

// File: tb/test_ctab_top.sv
module test_ctab_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_cmd;
  logic [12:0] cfg_data;
  logic        lk_req;
  logic [7:0]  lk_conn;
  logic [7:0]  lk_arrival;
  logic        rsp_valid;
  logic [7:0]  rsp_out_id;
  logic [4:0]  rsp_mask;
  logic [7:0]  rsp_deadline;
  logic [39:0] hz_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ctab_top i_ctab_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cmd(cfg_cmd), .cfg_data(cfg_data),
    .lk_req(lk_req), .lk_conn(lk_conn), .lk_arrival(lk_arrival),
    .rsp_valid(rsp_valid), .rsp_out_id(rsp_out_id), .rsp_mask(rsp_mask),
    .rsp_deadline(rsp_deadline), .hz_o(hz_o)
  );

  task automatic check(input string rq, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cmd_wr(input logic [2:0] c, input logic [12:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cmd = c; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] cin, input logic [7:0] oid,
                       input logic [7:0] dly, input logic [4:0] msk);
    cmd_wr(3'd0, {5'd0, oid});
    cmd_wr(3'd1, {5'd0, dly});
    cmd_wr(3'd2, {8'd0, msk});
    cmd_wr(3'd3, {5'd0, cin});
  endtask

  // request at one negedge, sample at the next (one posedge later)
  task automatic lookup(input logic [7:0] cin, input logic [7:0] arr);
    @(negedge clk);
    lk_req = 1'b1; lk_conn = cin; lk_arrival = arr;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; cfg_we = 1'b0; cfg_cmd = '0; cfg_data = '0;
    lk_req = 1'b0; lk_conn = '0; lk_arrival = '0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {39'd0, rsp_valid}, 40'd0);
    check("R1 horizons in reset", hz_o, 40'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid after reset", {39'd0, rsp_valid}, 40'd0);
    check("R1 horizons after reset", hz_o, 40'd0);
  endtask

  task automatic t_basic;
    setup(8'h12, 8'hA5, 8'h07, 5'b00100);
    lookup(8'h12, 8'h10);
    check("R3 valid after request", {39'd0, rsp_valid}, 40'd1);
    check("R8 next-hop id", {32'd0, rsp_out_id}, 40'hA5);
    check("R4 deadline 10+7", {32'd0, rsp_deadline}, 40'h17);
    check("R5 single port mask", {35'd0, rsp_mask}, 40'b00100);
    @(negedge clk);
    check("R3 valid drops", {39'd0, rsp_valid}, 40'd0);
  endtask

  task automatic t_wrap;
    setup(8'hFF, 8'h3C, 8'h30, 5'b00001);
    lookup(8'hFF, 8'hF0);
    check("R4 wrapped deadline", {32'd0, rsp_deadline}, 40'h20);
    lookup(8'hFF, 8'hCF);
    check("R4 deadline hits 255", {32'd0, rsp_deadline}, 40'hFF);
  endtask

  task automatic t_multicast;
    setup(8'h00, 8'h44, 8'h09, 5'b11011);
    lookup(8'h00, 8'h80);
    check("R5 multicast mask", {35'd0, rsp_mask}, 40'b11011);
    check("R5 shared deadline", {32'd0, rsp_deadline}, 40'h89);
    check("R8 multicast next id", {32'd0, rsp_out_id}, 40'h44);
  endtask

  task automatic t_staging;
    cmd_wr(3'd0, 13'h0EE);
    cmd_wr(3'd1, 13'h001);
    cmd_wr(3'd2, 13'h01F);
    lookup(8'h12, 8'h10);
    check("R2 staged id invisible", {32'd0, rsp_out_id}, 40'hA5);
    check("R2 staged mask invisible", {35'd0, rsp_mask}, 40'b00100);
    check("R2 staged delay invisible", {32'd0, rsp_deadline}, 40'h17);
  endtask

  task automatic t_same_cycle;
    // holding regs still EE/01/1F from t_staging; commit into index 12
    @(negedge clk);
    cfg_we = 1'b1; cfg_cmd = 3'd3; cfg_data = 13'h012;
    lk_req = 1'b1; lk_conn = 8'h12; lk_arrival = 8'h20;
    @(negedge clk);
    cfg_we = 1'b0; lk_req = 1'b0;
    check("R6 same-cycle old id", {32'd0, rsp_out_id}, 40'hA5);
    check("R6 same-cycle old deadline", {32'd0, rsp_deadline}, 40'h27);
    lookup(8'h12, 8'h20);
    check("R6 new id after commit", {32'd0, rsp_out_id}, 40'hEE);
    check("R6 new mask after commit", {35'd0, rsp_mask}, 40'b11111);
    check("R6 new deadline after commit", {32'd0, rsp_deadline}, 40'h21);
  endtask

  task automatic t_horizon;
    cmd_wr(3'd4, {5'b00101, 8'h33});
    check("R7 ports 0 and 2 set", hz_o, {8'h00, 8'h00, 8'h33, 8'h00, 8'h33});
    cmd_wr(3'd4, {5'b10010, 8'h07});
    check("R7 ports 1 and 4 set, others kept", hz_o, {8'h07, 8'h00, 8'h33, 8'h07, 8'h33});
  endtask

  task automatic t_reserved;
    setup(8'h50, 8'h61, 8'h02, 5'b01000);
    cmd_wr(3'd5, 13'h1FFF);
    cmd_wr(3'd6, 13'h1F99);
    cmd_wr(3'd7, 13'h1F50);
    check("R9 horizons untouched", hz_o, {8'h07, 8'h00, 8'h33, 8'h07, 8'h33});
    lookup(8'h50, 8'h00);
    check("R9 table untouched", {24'd0, rsp_out_id, rsp_deadline}, {24'd0, 8'h61, 8'h02});
    cmd_wr(3'd3, 13'h051);
    lookup(8'h51, 8'h00);
    check("R9 holding regs untouched", {19'd0, rsp_out_id, rsp_mask, rsp_deadline},
          {19'd0, 8'h61, 5'b01000, 8'h02});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_multicast();
    t_staging();
    t_same_cycle();
    t_horizon();
    t_reserved();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule